// File: doc/BRIEF.md
# Per-Channel Loopback and Output Steering

This block is the digital steering stage of one line transceiver channel. It sits between the system-side transmit bipolar rails with their clock, the receive rails and clock recovered from the line, and the line-side encoder input. It chooses where each output direction takes its data from: a normal path, a local loop (system transmit turned back to system receive), a remote loop (line receive turned back to line transmit), or both loops together. It also applies a polarity choice to the line output and forces outputs to safe values when the channel is powered down, when the system transmit clock stops, or when the line signal is lost.

A control word is written through `cfg_we`/`cfg_wdata`. A mode state machine follows it with the states PWRDN, NORMAL, LOCAL, REMOTE and DUAL. After reset the machine is in PWRDN. When the power-down bit is set it moves from any state to PWRDN. When the power-down bit is clear it goes to NORMAL, LOCAL, REMOTE or DUAL according to the two loop bits (none, local only, remote only, both). A second machine watches the system transmit clock against the block clock. It has two states. It leaves ACTIVE for LOST when `TCLK_TIMEOUT` block-clock cycles pass with no rising edge, and it goes from LOST back to ACTIVE on the next detected rising edge. The clock input passes through a three-stage sampler before edge detection. All outputs are registered: a data input appears at the outputs one clock later, and a control write reaches the loop selection three clocks later.

Top module: `chan_loop_ctrl`

## Requirements
- R1: After reset, `sys_rx_pos`, `sys_rx_neg`, `sys_rx_clk`, `line_tx_pos` and `line_tx_neg` are 0, while `los_out` and `tclk_lost` are 1. The control word resets to loop bits 0, polarity bit 1, power-down bit 1 and squelch-disable bit 0.
- R2: In NORMAL mode, one clock after they are sampled, the line rails follow the system transmit rails and the system receive rails and clock follow the recovered receive rails and clock.
- R3: With the polarity bit (`cfg_wdata[2]`) at 1, the line rails keep their order. With it at 0, the positive and negative line rails are swapped. This applies in every mode.
- R4: In LOCAL mode (`cfg_wdata[0]`=1), the system receive rails and clock follow the system transmit rails and clock, and the recovered receive inputs have no effect on them. The line rails still carry the system transmit rails, and `los_out` still follows `los_in`.
- R5: In REMOTE mode (`cfg_wdata[1]`=1), the line rails follow the recovered receive rails and the system transmit rails have no effect. The system receive outputs still follow the recovered receive inputs.
- R6: In DUAL mode (both loop bits set), the line rails come from the recovered receive rails and the system receive outputs come from the system transmit side.
- R7: `tclk_lost` rises once `TCLK_TIMEOUT` block-clock cycles pass without a rising edge of `sys_tx_clk`, and it falls again after edges return.
- R8: While `tclk_lost` is 1 and the line rails are taken from the system side (NORMAL or LOCAL), both line rails are 0. In REMOTE or DUAL the recovered data is still sent.
- R9: With the power-down bit (`cfg_wdata[3]`) set, `los_out` is 1 and both line rails are 0.
- R10: While `los_out` is 1 and the squelch-disable bit (`cfg_wdata[4]`) is 0, the system receive rails and clock are all 0. With that bit at 1 they pass unchanged.
- R11: A cycle with `cfg_we` high loads `cfg_wdata` into the control word, with bit 0 local loop, bit 1 remote loop, bit 2 polarity, bit 3 power-down and bit 4 squelch-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Control word value |
| sys_tx_pos | input | 1 | System transmit positive rail |
| sys_tx_neg | input | 1 | System transmit negative rail |
| sys_tx_clk | input | 1 | System transmit clock (sampled) |
| rec_pos | input | 1 | Recovered receive positive rail |
| rec_neg | input | 1 | Recovered receive negative rail |
| rec_clk | input | 1 | Recovered receive clock |
| los_in | input | 1 | Loss of signal from the line detector |
| line_tx_pos | output | 1 | Positive rail to the line encoder |
| line_tx_neg | output | 1 | Negative rail to the line encoder |
| sys_rx_pos | output | 1 | Receive positive rail to the system |
| sys_rx_neg | output | 1 | Receive negative rail to the system |
| sys_rx_clk | output | 1 | Receive clock to the system |
| los_out | output | 1 | Channel loss-of-signal status |
| tclk_lost | output | 1 | Transmit clock loss status |

## Verification
The bench builds the block with the default `TCLK_TIMEOUT` of 16. It toggles the transmit clock with half-periods of 4 and 7 block cycles. Both settings keep the gap between rising edges under the limit, so the status must stay low. It also stops the clock long enough to cross the limit, which reaches both transitions of the clock-loss machine in a run of a few hundred cycles. Every mode is reached through real control writes. Within each mode the bench varies the inputs the mode should ignore, so that any leakage from them shows at the outputs.

// File: rtl/chan_loop_pkg.sv
package chan_loop_pkg;

    typedef enum logic [2:0] {
        M_PWRDN  = 3'd0,
        M_NORMAL = 3'd1,
        M_LOCAL  = 3'd2,
        M_REMOTE = 3'd3,
        M_DUAL   = 3'd4
    } chan_mode_e;

    typedef enum logic {
        TC_LOST   = 1'b0,
        TC_ACTIVE = 1'b1
    } tclk_state_e;

    // Last member is bit 0.
    typedef struct packed {
        logic sq_dis;
        logic pwr_dn;
        logic pol_keep;
        logic rem_lb;
        logic loc_lb;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    localparam chan_cfg_t CFG_RESET = '{
        sq_dis:   1'b0,
        pwr_dn:   1'b1,
        pol_keep: 1'b1,
        rem_lb:   1'b0,
        loc_lb:   1'b0
    };

endpackage

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
    import chan_loop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output chan_cfg_t            cfg_o,
    output chan_mode_e           mode_o
);

    chan_cfg_t  cfg_q;
    chan_mode_e mode_q, mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= chan_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_PWRDN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        if (cfg_q.pwr_dn) begin
            mode_d = M_PWRDN;
        end else begin
            unique case ({cfg_q.rem_lb, cfg_q.loc_lb})
                2'b00: mode_d = M_NORMAL;
                2'b01: mode_d = M_LOCAL;
                2'b10: mode_d = M_REMOTE;
                2'b11: mode_d = M_DUAL;
            endcase
        end
    end

    assign cfg_o  = cfg_q;
    assign mode_o = mode_q;

    p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == chan_cfg_t'($past(cfg_wdata))));

    p_pwrdn_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.pwr_dn |=> (mode_q == M_PWRDN));

endmodule

// File: rtl/chan_tclk_mon.sv
module chan_tclk_mon
    import chan_loop_pkg::*;
#(
    parameter int TCLK_TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_in,
    output logic lost_o
);

    localparam int CW = (TCLK_TIMEOUT > 2) ? $clog2(TCLK_TIMEOUT) : 1;
    localparam logic [CW-1:0] LIM = CW'(TCLK_TIMEOUT - 1);

    logic [2:0]    samp_q;
    logic          edge_det;
    logic [CW-1:0] cnt_q, cnt_d;
    tclk_state_e   st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= {samp_q[1:0], tclk_in};
    end

    assign edge_det = samp_q[1] & ~samp_q[2];

    always_comb begin
        if (edge_det)        cnt_d = '0;
        else if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TC_ACTIVE: if (!edge_det && cnt_q == LIM) st_d = TC_LOST;
            TC_LOST:   if (edge_det)                  st_d = TC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LIM;
            st_q  <= TC_LOST;
        end else begin
            cnt_q <= cnt_d;
            st_q  <= st_d;
        end
    end

    assign lost_o = (st_q == TC_LOST);

    p_edge_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> !lost_o);

    p_loss_needs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> !$past(edge_det));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

endmodule

// File: rtl/chan_steer.sv
module chan_steer
    import chan_loop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_cfg_t  cfg_i,
    input  chan_mode_e mode_i,
    input  logic       tclk_lost_i,
    input  logic       sys_tx_pos_i,
    input  logic       sys_tx_neg_i,
    input  logic       sys_tx_clk_i,
    input  logic       rec_pos_i,
    input  logic       rec_neg_i,
    input  logic       rec_clk_i,
    input  logic       los_in_i,
    output logic       line_pos_o,
    output logic       line_neg_o,
    output logic       sys_rx_pos_o,
    output logic       sys_rx_neg_o,
    output logic       sys_rx_clk_o,
    output logic       los_o
);

    logic remote_src, local_src, pwrdn, line_kill, los_d, squelch;
    logic src_p, src_n, lp_d, ln_d;
    logic rp_d, rn_d, rc_d;

    always_comb begin
        pwrdn      = (mode_i == M_PWRDN);
        remote_src = (mode_i == M_REMOTE) || (mode_i == M_DUAL);
        local_src  = (mode_i == M_LOCAL)  || (mode_i == M_DUAL);

        src_p = remote_src ? rec_pos_i : sys_tx_pos_i;
        src_n = remote_src ? rec_neg_i : sys_tx_neg_i;
        line_kill = pwrdn || (!remote_src && tclk_lost_i);
        if (line_kill) begin
            lp_d = 1'b0;
            ln_d = 1'b0;
        end else if (cfg_i.pol_keep) begin
            lp_d = src_p;
            ln_d = src_n;
        end else begin
            lp_d = src_n;
            ln_d = src_p;
        end

        los_d   = los_in_i || pwrdn;
        squelch = los_d && !cfg_i.sq_dis;
        if (squelch) begin
            rp_d = 1'b0;
            rn_d = 1'b0;
            rc_d = 1'b0;
        end else if (local_src) begin
            rp_d = sys_tx_pos_i;
            rn_d = sys_tx_neg_i;
            rc_d = sys_tx_clk_i;
        end else begin
            rp_d = rec_pos_i;
            rn_d = rec_neg_i;
            rc_d = rec_clk_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_pos_o   <= 1'b0;
            line_neg_o   <= 1'b0;
            sys_rx_pos_o <= 1'b0;
            sys_rx_neg_o <= 1'b0;
            sys_rx_clk_o <= 1'b0;
            los_o        <= 1'b1;
        end else begin
            line_pos_o   <= lp_d;
            line_neg_o   <= ln_d;
            sys_rx_pos_o <= rp_d;
            sys_rx_neg_o <= rn_d;
            sys_rx_clk_o <= rc_d;
            los_o        <= los_d;
        end
    end

    p_pwrdn_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_PWRDN) |=> (los_o && !line_pos_o && !line_neg_o));

    p_squelch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (los_in_i && !cfg_i.sq_dis) |=> (!sys_rx_pos_o && !sys_rx_neg_o && !sys_rx_clk_o));

    p_tclk_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tclk_lost_i && (mode_i == M_NORMAL || mode_i == M_LOCAL))
        |=> (!line_pos_o && !line_neg_o));

    p_remote_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_REMOTE && cfg_i.pol_keep) |=> (line_pos_o == $past(rec_pos_i)));

endmodule

// File: rtl/chan_loop_ctrl.sv
module chan_loop_ctrl
    import chan_loop_pkg::*;
#(
    parameter int TCLK_TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [4:0] cfg_wdata,
    input  logic       sys_tx_pos,
    input  logic       sys_tx_neg,
    input  logic       sys_tx_clk,
    input  logic       rec_pos,
    input  logic       rec_neg,
    input  logic       rec_clk,
    input  logic       los_in,
    output logic       line_tx_pos,
    output logic       line_tx_neg,
    output logic       sys_rx_pos,
    output logic       sys_rx_neg,
    output logic       sys_rx_clk,
    output logic       los_out,
    output logic       tclk_lost
);

    chan_cfg_t  cfg;
    chan_mode_e mode;
    logic       lost;

    chan_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg),
        .mode_o    (mode)
    );

    chan_tclk_mon #(.TCLK_TIMEOUT(TCLK_TIMEOUT)) u_tmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .tclk_in (sys_tx_clk),
        .lost_o  (lost)
    );

    chan_steer u_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_i        (cfg),
        .mode_i       (mode),
        .tclk_lost_i  (lost),
        .sys_tx_pos_i (sys_tx_pos),
        .sys_tx_neg_i (sys_tx_neg),
        .sys_tx_clk_i (sys_tx_clk),
        .rec_pos_i    (rec_pos),
        .rec_neg_i    (rec_neg),
        .rec_clk_i    (rec_clk),
        .los_in_i     (los_in),
        .line_pos_o   (line_tx_pos),
        .line_neg_o   (line_tx_neg),
        .sys_rx_pos_o (sys_rx_pos),
        .sys_rx_neg_o (sys_rx_neg),
        .sys_rx_clk_o (sys_rx_clk),
        .los_o        (los_out)
    );

    assign tclk_lost = lost;

endmodule

// File: tb/chan_loop_ctrl_test.sv
module chan_loop_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic sys_tx_pos = 1'b0, sys_tx_neg = 1'b0, sys_tx_clk = 1'b0;
    logic rec_pos = 1'b0, rec_neg = 1'b0, rec_clk = 1'b0, los_in = 1'b0;
    logic line_tx_pos, line_tx_neg, sys_rx_pos, sys_rx_neg, sys_rx_clk, los_out, tclk_lost;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int tclk_half = 0;
    int tcnt = 0;
    logic tclk_seen = 1'b0;
    logic [4:0] cur_cfg = 5'b01100;
    logic exp_lost = 1'b1;

    always #4 clk = ~clk;

    chan_loop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sys_tx_pos(sys_tx_pos), .sys_tx_neg(sys_tx_neg), .sys_tx_clk(sys_tx_clk),
        .rec_pos(rec_pos), .rec_neg(rec_neg), .rec_clk(rec_clk), .los_in(los_in),
        .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg),
        .sys_rx_pos(sys_rx_pos), .sys_rx_neg(sys_rx_neg), .sys_rx_clk(sys_rx_clk),
        .los_out(los_out), .tclk_lost(tclk_lost)
    );

    always @(negedge clk) begin
        if (tclk_half == 0) tcnt <= 0;
        else if (tcnt >= tclk_half - 1) begin
            tcnt <= 0;
            sys_tx_clk <= ~sys_tx_clk;
        end else tcnt <= tcnt + 1;
    end

    always @(posedge clk) tclk_seen <= sys_tx_clk;

    // Vector: {line_p, line_n, rx_p, rx_n, rx_clk, los, tclk_lost}
    function automatic logic [6:0] model(input logic [4:0] c, input logic lost);
        logic loc, rem, pol, pd, sq, lp, ln, rp, rn, rc, los, t;
        loc = c[0]; rem = c[1]; pol = c[2]; pd = c[3]; sq = c[4];
        lp = (rem && !pd) ? rec_pos : sys_tx_pos;
        ln = (rem && !pd) ? rec_neg : sys_tx_neg;
        if (pd || (!(rem && !pd) && lost)) begin lp = 0; ln = 0; end
        if (!pol) begin t = lp; lp = ln; ln = t; end
        if (loc && !pd) begin rp = sys_tx_pos; rn = sys_tx_neg; rc = tclk_seen; end
        else begin rp = rec_pos; rn = rec_neg; rc = rec_clk; end
        los = los_in || pd;
        if (los && !sq) begin rp = 0; rn = 0; rc = 0; end
        return {lp, ln, rp, rn, rc, los, lost};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [6:0] obs();
        return {line_tx_pos, line_tx_neg, sys_rx_pos, sys_rx_neg, sys_rx_clk, los_out, tclk_lost};
    endfunction

    task automatic set_cfg(input logic [4:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        cur_cfg = v;
    endtask

    task automatic step(input string req, input logic rp, rn, rc, tp, tn, li);
        rec_pos = rp; rec_neg = rn; rec_clk = rc;
        sys_tx_pos = tp; sys_tx_neg = tn; los_in = li;
        @(posedge clk);
        @(negedge clk);
        chk(req, obs(), model(cur_cfg, exp_lost));
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", obs(), 7'b0000011);
    endtask

    task automatic t_normal();
        set_cfg(5'b00100);
        step("R2 normal a", 1, 0, 1, 0, 1, 0);
        step("R2 normal b", 0, 1, 0, 1, 0, 0);
        step("R2 normal c", 1, 0, 0, 1, 0, 0);
        step("R2 normal d", 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_polarity();
        set_cfg(5'b00000);
        step("R3 swap a", 0, 1, 1, 1, 0, 0);
        step("R3 swap b", 1, 0, 0, 0, 1, 0);
        set_cfg(5'b00010);
        step("R3 swap remote", 1, 0, 1, 0, 1, 0);
        set_cfg(5'b00100);
    endtask

    task automatic t_local();
        set_cfg(5'b00101);
        step("R4 local a", 1, 0, 1, 0, 1, 0);
        step("R4 local rec ignored", 0, 1, 0, 0, 1, 0);
        step("R4 local b", 0, 1, 1, 1, 0, 0);
        set_cfg(5'b10101);
        step("R4 local los active", 1, 0, 1, 1, 0, 1);
    endtask

    task automatic t_remote();
        set_cfg(5'b00110);
        step("R5 remote a", 1, 0, 1, 0, 1, 0);
        step("R5 remote sys ignored", 1, 0, 1, 1, 0, 0);
        step("R5 remote b", 0, 1, 0, 1, 0, 0);
        tclk_half = 0;
        repeat (30) @(negedge clk);
        exp_lost = 1'b1;
        step("R8 remote sends despite lost clock", 0, 1, 1, 1, 0, 0);
        tclk_half = 4;
        repeat (20) @(negedge clk);
        exp_lost = 1'b0;
    endtask

    task automatic t_dual();
        set_cfg(5'b00111);
        step("R6 dual a", 1, 0, 0, 0, 1, 0);
        step("R6 dual b", 0, 1, 1, 1, 0, 0);
    endtask

    task automatic t_tclk();
        set_cfg(5'b00100);
        tclk_half = 7;
        repeat (40) @(negedge clk);
        exp_lost = 1'b0;
        step("R7 slow clock stays present", 0, 0, 0, 1, 0, 0);
        tclk_half = 0;
        repeat (30) @(negedge clk);
        exp_lost = 1'b1;
        step("R7 stopped clock flagged", 0, 0, 0, 1, 0, 0);
        step("R8 line zero on lost clock", 1, 0, 0, 0, 1, 0);
        tclk_half = 4;
        repeat (20) @(negedge clk);
        exp_lost = 1'b0;
        step("R7 lost cleared on return", 0, 0, 0, 1, 0, 0);
    endtask

    task automatic t_pwrdn();
        set_cfg(5'b01110);
        step("R9 powerdown", 1, 0, 1, 1, 0, 0);
        set_cfg(5'b11101);
        step("R9 powerdown sq disabled", 1, 0, 1, 0, 1, 0);
    endtask

    task automatic t_squelch();
        set_cfg(5'b00100);
        step("R10 squelch on los", 1, 0, 1, 0, 1, 1);
        set_cfg(5'b10100);
        step("R10 squelch disabled", 1, 0, 1, 0, 1, 1);
        step("R11 control word held", 0, 1, 0, 1, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        tclk_half = 4;
        repeat (20) @(negedge clk);
        exp_lost = 1'b0;
        t_normal();
        t_polarity();
        t_local();
        t_remote();
        t_dual();
        t_tclk();
        t_pwrdn();
        t_squelch();
        finish_run();
    end

endmodule